// File: doc/BRIEF.md
# Masked BCD Alarm Comparator

This block watches six running calendar-time fields (seconds, minutes, hours, weekday, day of month, month), supplied as BCD bytes by a time counter elsewhere on the chip. It compares them against six software-programmed alarm bytes. Each alarm byte carries its own compare enable beside its BCD target. A field whose enable is clear counts as matching whatever the time shows. This makes partial alarms possible, such as "at minute 30 of every hour" or "every day at 06:00:00".

When all enabled fields agree with the time, a small watch state machine catches the rising edge of that condition and sets a sticky alarm flag once. The interrupt line is the flag gated by an interrupt enable. Software reaches the alarm bytes and the control byte through a byte-wide register bus with a combinational read path. It clears the flag by writing a zero to the flag bit.

The watch machine has two states. ST_WAIT means the match condition is absent. ST_HELD means a match has been seen and has not yet gone away. The transition ST_WAIT to ST_HELD happens when the match appears, and it emits the one-cycle set request. The transition ST_HELD to ST_WAIT happens when the match disappears. No other transition exists.

Top module: `bcd_alarm_cmp`

## Requirements
- R1: After reset every alarm byte and the control byte read as 0x00, and `alarm_irq` is 0.
- R2: Bus addresses 0 to 5 hold the alarm bytes for seconds, minutes, hours, weekday, day of month and month, in that order. A write stores the whole byte, and a read returns it unchanged. Address 6 is the control byte: bit 0 is the alarm flag, bit 3 is the interrupt enable, and its other bits read 0. Address 7 reads 0x00, and writes to it change nothing.
- R3: In an alarm byte, bit 7 is the compare enable. When bit 7 is 1, the field matches only if the time byte equals {0, bits 6..0 of the alarm byte}. When bit 7 is 0, the field always matches.
- R4: When every field matches and at least one field is enabled, the flag reads 1 from the first clock edge after that condition appears.
- R5: `alarm_irq` equals the flag ANDed with the interrupt enable. The enable alone never raises it, and setting the enable while the flag is 1 raises it without a clock edge.
- R6: The flag is set only when the match condition rises. If software clears the flag while the match persists, the flag stays 0 until the match goes away and comes back.
- R7: When all six compare enables are 0, the flag is never set, whatever the time inputs show.
- R8: A control write with bit 0 equal to 0 clears the flag at that clock edge. A write with bit 0 equal to 1 leaves the flag unchanged, so software cannot set it. If a set request and a clear write land on the same edge, the set wins and the flag reads 1.
- R9: The month and hour fields compare all BCD digits. An alarm month of 0x12 matches a month counter of 0x12 but not 0x02, and an alarm hour of 0x23 does not match 0x22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe, sampled at the clock edge |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from `bus_addr` |
| time_sec | input | 8 | Current seconds, BCD |
| time_min | input | 8 | Current minutes, BCD |
| time_hour | input | 8 | Current hours, BCD |
| time_wday | input | 8 | Current weekday, BCD |
| time_mday | input | 8 | Current day of month, BCD |
| time_mon | input | 8 | Current month, BCD 1 to 12 |
| alarm_irq | output | 1 | Alarm interrupt: flag AND enable |

## Verification
The match condition is combinational from the time inputs and the alarm bytes. The flag is therefore due one clock edge after a time change, and two edges after an alarm-byte write, because the write edge comes first. Read data and `alarm_irq` follow register state without further delay. The bench drives every stimulus just after a falling edge and samples just after the next falling edge, so each flag check sits exactly one rising edge after the stimulus that should cause it. A sweep covers all 64 enable masks against all 64 per-field mismatch patterns, and the expected flag is computed as "mask nonzero and no enabled field mismatched". Directed sequences then cover held matches, clear-versus-set collisions and enable gating, one edge at a time.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;

    // Control byte layout; software and the bench decode these positions.
    localparam int FLAG_BIT   = 0;
    localparam int IRQ_EN_BIT = 3;

    // Watch state: is a full match currently present?
    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_HELD = 1'b1
    } watch_state_e;

endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] alarm_byte,
    input  logic [DATA_W-1:0] time_byte,
    output logic              field_en,
    output logic              field_hit
);
    localparam int VAL_W = DATA_W - 1;

    logic [DATA_W-1:0] target;

    always_comb begin
        field_en  = alarm_byte[DATA_W-1];
        target    = {1'b0, alarm_byte[VAL_W-1:0]};
        field_hit = !field_en || (target == time_byte);
    end

endmodule

// File: rtl/alarm_regfile.sv
module alarm_regfile
    import bcd_alarm_pkg::*;
#(
    parameter int NUM_FIELDS = 6,
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [DATA_W-1:0]                 wdata,
    input  logic                              flag_set,
    output logic [NUM_FIELDS-1:0][DATA_W-1:0] alarm_regs,
    output logic                              ctrl_flag,
    output logic                              ctrl_irq_en,
    output logic [DATA_W-1:0]                 rdata
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_FIELDS);

    logic ctrl_wr;
    assign ctrl_wr = wr_en && (addr == CTRL_ADDR);

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field_reg
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                alarm_regs[g] <= '0;
            end else if (wr_en && (addr == MY_ADDR)) begin
                alarm_regs[g] <= wdata;
            end
        end
    end

    // Flag: a set request has priority over a software clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_flag <= 1'b0;
        end else if (flag_set) begin
            ctrl_flag <= 1'b1;
        end else if (ctrl_wr && !wdata[FLAG_BIT]) begin
            ctrl_flag <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_irq_en <= 1'b0;
        end else if (ctrl_wr) begin
            ctrl_irq_en <= wdata[IRQ_EN_BIT];
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (addr == ADDR_W'(i)) begin
                rdata = alarm_regs[i];
            end
        end
        if (addr == CTRL_ADDR) begin
            rdata[FLAG_BIT]   = ctrl_flag;
            rdata[IRQ_EN_BIT] = ctrl_irq_en;
        end
    end

endmodule

// File: rtl/alarm_watch_fsm.sv
module alarm_watch_fsm
    import bcd_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match_now,
    output logic set_pulse
);
    watch_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: if (match_now)  state_d = ST_HELD;
            ST_HELD: if (!match_now) state_d = ST_WAIT;
            default: state_d = ST_WAIT;
        endcase
    end

    always_comb begin
        set_pulse = 1'b0;
        unique case (state_q)
            ST_WAIT: set_pulse = match_now;
            ST_HELD: set_pulse = 1'b0;
            default: set_pulse = 1'b0;
        endcase
    end

endmodule

// File: rtl/bcd_alarm_cmp.sv
module bcd_alarm_cmp #(
    parameter int NUM_FIELDS = 6,
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] time_sec,
    input  logic [DATA_W-1:0] time_min,
    input  logic [DATA_W-1:0] time_hour,
    input  logic [DATA_W-1:0] time_wday,
    input  logic [DATA_W-1:0] time_mday,
    input  logic [DATA_W-1:0] time_mon,
    output logic              alarm_irq
);
    logic [NUM_FIELDS-1:0][DATA_W-1:0] alarm_regs;
    logic [NUM_FIELDS-1:0][DATA_W-1:0] time_vec;
    logic [NUM_FIELDS-1:0]             field_en;
    logic [NUM_FIELDS-1:0]             field_hit;
    logic                              any_en;
    logic                              match_all;
    logic                              set_pulse;
    logic                              ctrl_flag;
    logic                              ctrl_irq_en;

    // Same order as the alarm byte addresses.
    assign time_vec = {time_mon, time_mday, time_wday, time_hour, time_min, time_sec};

    alarm_regfile #(
        .NUM_FIELDS (NUM_FIELDS),
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bus_wr),
        .addr        (bus_addr),
        .wdata       (bus_wdata),
        .flag_set    (set_pulse),
        .alarm_regs  (alarm_regs),
        .ctrl_flag   (ctrl_flag),
        .ctrl_irq_en (ctrl_irq_en),
        .rdata       (bus_rdata)
    );

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
        alarm_field_cmp #(
            .DATA_W (DATA_W)
        ) u_cmp (
            .alarm_byte (alarm_regs[g]),
            .time_byte  (time_vec[g]),
            .field_en   (field_en[g]),
            .field_hit  (field_hit[g])
        );
    end

    assign any_en    = |field_en;
    assign match_all = any_en && (&field_hit);

    alarm_watch_fsm u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .match_now (match_all),
        .set_pulse (set_pulse)
    );

    assign alarm_irq = ctrl_flag && ctrl_irq_en;

endmodule

// File: rtl/bcd_alarm_chk.sv
module bcd_alarm_chk #(
    parameter int ADDR_W     = 3,
    parameter int NUM_FIELDS = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wdata_flag,
    input logic              match_all,
    input logic              any_en,
    input logic              set_pulse,
    input logic              alarm_flag,
    input logic              irq_en,
    input logic              alarm_irq
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_FIELDS);

    // R4: a rising match produces the flag at the next edge
    a_r4_flag_after_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_all) |=> alarm_flag);

    // R5: no interrupt without the enable
    a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !alarm_irq);

    // R6: the flag only rises after a match was present
    a_r6_flag_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(match_all));

    // R6: one set request per match episode
    a_r6_single_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |=> !set_pulse);

    // R7: fully masked alarm never sets the flag
    a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_en && !alarm_flag) |=> !alarm_flag);

    // R8: a clear write without a competing set empties the flag
    a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == CTRL_ADDR) && !wdata_flag && !set_pulse) |=> !alarm_flag);

endmodule

bind bcd_alarm_cmp bcd_alarm_chk #(
    .ADDR_W     (ADDR_W),
    .NUM_FIELDS (NUM_FIELDS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .wdata_flag (bus_wdata[0]),
    .match_all  (match_all),
    .any_en     (any_en),
    .set_pulse  (set_pulse),
    .alarm_flag (ctrl_flag),
    .irq_en     (ctrl_irq_en),
    .alarm_irq  (alarm_irq)
);

// File: tb/bcd_alarm_cmp_tb.sv
`timescale 1ns/1ps
module bcd_alarm_cmp_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] tv [6];
    logic       alarm_irq;
    logic [7:0] base [6];
    logic [7:0] alt  [6];
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bcd_alarm_cmp u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .time_sec  (tv[0]),
        .time_min  (tv[1]),
        .time_hour (tv[2]),
        .time_wday (tv[3]),
        .time_mday (tv[4]),
        .time_mon  (tv[5]),
        .alarm_irq (alarm_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_time_alt();
        for (int f = 0; f < 6; f++) tv[f] = alt[f];
    endtask

    task automatic set_time_match();
        for (int f = 0; f < 6; f++) tv[f] = base[f];
    endtask

    task automatic chk_ctrl(input string req, input logic [7:0] exp_ctrl, input logic exp_irq);
        logic [7:0] r;
        rd(3'd6, r);
        check(req, r, exp_ctrl);
        check(req, {7'd0, alarm_irq}, {7'd0, exp_irq});
    endtask

    initial begin
        #(20ns * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        base = '{8'h45, 8'h30, 8'h23, 8'h06, 8'h31, 8'h12};
        alt  = '{8'h44, 8'h31, 8'h22, 8'h05, 8'h30, 8'h02};
        set_time_alt();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), r);
            check("R1", r, 8'h00);
        end
        check("R1", {7'd0, alarm_irq}, 8'h00);

        // R2: readback of alarm bytes, control layout, unused address
        for (int a = 0; a < 6; a++) wr(3'(a), 8'hA0 + 8'(a * 5));
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), r);
            check("R2", r, 8'hA0 + 8'(a * 5));
        end
        wr(3'd7, 8'hFF);
        rd(3'd7, r);
        check("R2", r, 8'h00);
        // R8: writing 1 to the flag bit cannot set it
        wr(3'd6, 8'hFF);
        chk_ctrl("R8", 8'h08, 1'b0);

        // R3 R4 R7 R9: sweep of enable masks against mismatch patterns
        for (int m = 0; m < 64; m++) begin
            for (int f = 0; f < 6; f++) wr(3'(f), base[f] | (m[f] ? 8'h80 : 8'h00));
            for (int p = 0; p < 64; p++) begin
                logic exp_f;
                set_time_alt();
                tick();
                wr(3'd6, 8'h08);
                for (int f = 0; f < 6; f++) tv[f] = p[f] ? alt[f] : base[f];
                tick();
                exp_f = (m != 0) && ((p & m) == 0);
                chk_ctrl(m == 0 ? "R7" : "R3_R4_R9", {4'd0, 1'b1, 2'd0, exp_f}, exp_f);
            end
        end

        // Alarm bytes now all enabled (mask 63).
        // R6: held match after a clear does not set again
        set_time_alt(); tick();
        wr(3'd6, 8'h08);
        set_time_match(); tick();
        chk_ctrl("R6", 8'h09, 1'b1);
        wr(3'd6, 8'h08);
        chk_ctrl("R6", 8'h08, 1'b0);
        repeat (3) tick();
        chk_ctrl("R6", 8'h08, 1'b0);
        set_time_alt(); tick();
        set_time_match(); tick();
        chk_ctrl("R6", 8'h09, 1'b1);

        // R5: flag without enable gives no interrupt; enabling raises it
        wr(3'd6, 8'h00);
        set_time_alt(); tick();
        set_time_match(); tick();
        chk_ctrl("R5", 8'h01, 1'b0);
        bus_wr = 1'b1; bus_addr = 3'd6; bus_wdata = 8'h09;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        check("R5", {7'd0, alarm_irq}, 8'h01);
        @(negedge clk);
        chk_ctrl("R5", 8'h09, 1'b1);

        // R8: clear, then a clear colliding with a new set request
        set_time_alt(); tick();
        wr(3'd6, 8'h08);
        chk_ctrl("R8", 8'h08, 1'b0);
        set_time_match();
        wr(3'd6, 8'h08);
        chk_ctrl("R8", 8'h09, 1'b1);

        // R9: month tens digit matters with only the month enabled
        for (int f = 0; f < 5; f++) wr(3'(f), base[f]);
        set_time_alt(); tick();
        wr(3'd6, 8'h08);
        tv[5] = 8'h12; tick();
        chk_ctrl("R9", 8'h09, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule